// File: doc/BRIEF.md
# Row/Column Decoded Word Memory with Fetch/Store Sequencer

This block is a word-addressed storage array. It has an address holding register and a data holding register. Software-free control logic uses them to read or write one cell at a time. The user first loads the address register, and for a write also the data register. The user then raises a request strobe with an operation select. A small sequencer steps through one access cycle and reports completion with a single-cycle done pulse. After a read, the data register holds the contents of the addressed cell.

Cells are not picked by one flat decoder. The address is split into a high half and a low half, and each half feeds its own one-hot decoder. The high half selects a row line and the low half selects a column line. A cell takes part in an access only where its row line and its column line are both high. Every access, read or write, takes the same number of cycles whatever the address.

Top module: `ram2d_ctrl`

## Requirements
- R1: After reset, `mar_q` and `mdr_q` read zero, `done` is low, and the sequencer is idle.
- R2: While idle, `mar_ld` copies `mar_in` into `mar_q` at the next clock edge, and `mdr_ld` copies `mdr_in` into `mdr_q` at the next clock edge.
- R3: A store (`op` = 1) accepted from idle writes the value in `mdr_q` into the cell addressed by `mar_q`.
- R4: A fetch (`op` = 0) accepted from idle places the addressed cell's contents in `mdr_q`, and they are visible no later than the cycle in which `done` is high.
- R5: `done` is high for exactly one cycle per accepted request, in the second cycle after the edge that accepts the request.
- R6: Address bits [11:6] select one of 64 rows and bits [5:0] select one of 64 columns. Addresses that share only a row or only a column never alias each other.
- R7: `mar_ld` and `mdr_ld` are ignored while an operation is in progress.
- R8: `req` is ignored while an operation is in progress. A request held high through a busy period produces only one `done` pulse.
- R9: The access latency is the same for every address, including the lowest and highest cells.
- R10: During an access, each decoder drives exactly one line. At most one cell is write-enabled in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mar_ld | input | 1 | Load `mar_in` into the address register (idle only) |
| mar_in | input | 12 | New address value |
| mdr_ld | input | 1 | Load `mdr_in` into the data register (idle only) |
| mdr_in | input | 16 | New data value |
| req | input | 1 | Request strobe, accepted only when idle |
| op | input | 1 | Operation select: 0 fetch, 1 store |
| mar_q | output | 12 | Current address register contents |
| mdr_q | output | 16 | Current data register contents |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default geometry of 6 row bits, 6 column bits and 16-bit words, so the full 4K address space is within reach. This covers the corner cells at 0x000 and 0xFFF, and it covers address pairs that share only a row or only a column, so a swapped or truncated address half shows up as aliasing. Latency is counted edge by edge for several addresses, and the register loads and request strobe are driven during busy cycles to show they are ignored.

// File: rtl/ram2d_pkg.sv
package ram2d_pkg;
  typedef enum logic {
    OP_FETCH = 1'b0,
    OP_STORE = 1'b1
  } mem_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ACCESS = 2'd1,
    SQ_DONE   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ram2d_onehot_dec.sv
module ram2d_onehot_dec #(
  parameter int IN_W = 6,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IN_W-1:0]  sel,
  output logic [OUT_N-1:0] lines
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign lines[i] = en && (sel == IN_W'(i));
  end

  // R10: an enabled decoder drives exactly one line, a disabled one drives none
  assert_dec_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(lines) == 1);
  assert_dec_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> lines == '0);
endmodule

// File: rtl/ram2d_array.sv
module ram2d_array #(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 6,
  parameter int DATA_W   = 16,
  localparam int ROWS  = 1 << ROW_BITS,
  localparam int COLS  = 1 << COL_BITS,
  localparam int AW    = ROW_BITS + COL_BITS,
  localparam int CELLS = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROWS-1:0]   row_sel,
  input  logic [COLS-1:0]   col_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [CELLS];
  logic [DATA_W-1:0] row_words [COLS];
  logic              any_row;
  logic              any_col;

  // Cell write: only where both the row line and the column line are high
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          if (row_sel[r] && col_sel[c]) cells[AW'(r * COLS + c)] <= wdata;
        end
      end
    end
  end

  // Read path: the row lines pick one row of words, the column lines pick one word
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      row_words[c] = '0;
      for (int r = 0; r < ROWS; r++) begin
        if (row_sel[r]) row_words[c] = row_words[c] | cells[AW'(r * COLS + c)];
      end
    end
    rdata = '0;
    for (int c = 0; c < COLS; c++) begin
      if (col_sel[c]) rdata = rdata | row_words[c];
    end
  end

  assign any_row = |row_sel;
  assign any_col = |col_sel;

  // R10: a write always lands on one intersection, never on a partial selection
  assert_write_has_cell_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (any_row && any_col && $onehot0(row_sel) && $onehot0(col_sel)));
endmodule

// File: rtl/ram2d_fsc.sv
module ram2d_fsc
  import ram2d_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic op,
  output logic idle,
  output logic access,
  output logic store_now,
  output logic fetch_now,
  output logic done
);
  seq_state_e state_q;
  mem_op_e    op_q;
  logic       accept;

  assign accept = (state_q == SQ_IDLE) && req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      op_q    <= OP_FETCH;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (accept) begin
          state_q <= SQ_ACCESS;
          op_q    <= mem_op_e'(op);
        end
        SQ_ACCESS: state_q <= SQ_DONE;
        SQ_DONE:   state_q <= SQ_IDLE;
        default:   state_q <= SQ_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == SQ_IDLE);
  assign access    = (state_q == SQ_ACCESS);
  assign store_now = access && (op_q == OP_STORE);
  assign fetch_now = access && (op_q == OP_FETCH);
  assign done      = (state_q == SQ_DONE);

  // R5: done follows an access cycle and lasts one cycle
  assert_done_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(access));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: an accepted request always leads to an access on the next cycle
  assert_accept_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> access);
endmodule

// File: rtl/ram2d_ctrl.sv
module ram2d_ctrl #(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 6,
  parameter int DATA_W   = 16,
  localparam int AW   = ROW_BITS + COL_BITS,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mar_ld,
  input  logic [AW-1:0]     mar_in,
  input  logic              mdr_ld,
  input  logic [DATA_W-1:0] mdr_in,
  input  logic              req,
  input  logic              op,
  output logic [AW-1:0]     mar_q,
  output logic [DATA_W-1:0] mdr_q,
  output logic              done
);
  function automatic logic [ROW_BITS-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1:COL_BITS];
  endfunction

  function automatic logic [COL_BITS-1:0] col_of(input logic [AW-1:0] a);
    return a[COL_BITS-1:0];
  endfunction

  logic              idle;
  logic              access;
  logic              store_now;
  logic              fetch_now;
  logic [ROWS-1:0]   row_lines;
  logic [COLS-1:0]   col_lines;
  logic [DATA_W-1:0] cell_rdata;

  ram2d_fsc u_fsc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .op        (op),
    .idle      (idle),
    .access    (access),
    .store_now (store_now),
    .fetch_now (fetch_now),
    .done      (done)
  );

  ram2d_onehot_dec #(.IN_W(ROW_BITS)) u_row_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (access),
    .sel   (row_of(mar_q)),
    .lines (row_lines)
  );

  ram2d_onehot_dec #(.IN_W(COL_BITS)) u_col_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (access),
    .sel   (col_of(mar_q)),
    .lines (col_lines)
  );

  ram2d_array #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .DATA_W   (DATA_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_sel (row_lines),
    .col_sel (col_lines),
    .wr_en   (store_now),
    .wdata   (mdr_q),
    .rdata   (cell_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
    end else if (idle && mar_ld) begin
      mar_q <= mar_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr_q <= '0;
    end else if (fetch_now) begin
      mdr_q <= cell_rdata;
    end else if (idle && mdr_ld) begin
      mdr_q <= mdr_in;
    end
  end

  // R7: the holding registers do not move under load strobes while busy
  assert_mar_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mar_q));
  assert_mdr_hold_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    store_now |=> $stable(mdr_q));
  // R2: an idle load lands on the next edge
  assert_mar_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && mar_ld) |=> mar_q == $past(mar_in));
  // R10: during an access the row and column decoders both drive one line
  assert_cross_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    access |-> ($onehot0(row_lines) && $onehot0(col_lines) && (|row_lines) && (|col_lines)));
endmodule

// File: tb/ram2d_ctrl_tb.sv
module ram2d_ctrl_tb;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mar_ld = 1'b0;
  logic [AW-1:0] mar_in = '0;
  logic          mdr_ld = 1'b0;
  logic [DW-1:0] mdr_in = '0;
  logic          req = 1'b0;
  logic          op = 1'b0;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] mdr_q;
  logic          done;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ram2d_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mar_ld(mar_ld), .mar_in(mar_in),
    .mdr_ld(mdr_ld), .mdr_in(mdr_in), .req(req), .op(op),
    .mar_q(mar_q), .mdr_q(mdr_q), .done(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_regs(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic with_d);
    mar_ld = 1'b1; mar_in = a;
    mdr_ld = with_d; mdr_in = d;
    tick();
    mar_ld = 1'b0; mdr_ld = 1'b0;
  endtask

  // Issue one request and check done timing: low after accept edge, high after next, low after that
  task automatic run_op(input logic o, input string tag);
    op = o; req = 1'b1;
    tick();
    req = 1'b0;
    check({tag, " done low in access"}, 32'(done), 32'd0);
    tick();
    check({tag, " done high second cycle"}, 32'(done), 32'd1);
    tick();
    check({tag, " done single cycle"}, 32'(done), 32'd0);
  endtask

  task automatic store_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    load_regs(a, d, 1'b1);
    run_op(1'b1, "R3/R5 store");
  endtask

  task automatic fetch_word(input logic [AW-1:0] a, output logic [DW-1:0] d);
    load_regs(a, '0, 1'b1);
    run_op(1'b0, "R4/R5 fetch");
    d = mdr_q;
  endtask

  task automatic t_reset();
    check("R1 mar_q zero", 32'(mar_q), 32'd0);
    check("R1 mdr_q zero", 32'(mdr_q), 32'd0);
    check("R1 done low", 32'(done), 32'd0);
  endtask

  task automatic t_load();
    load_regs(12'hA5C, 16'h1234, 1'b1);
    check("R2 mar load", 32'(mar_q), 32'hA5C);
    check("R2 mdr load", 32'(mdr_q), 32'h1234);
  endtask

  task automatic t_store_fetch();
    logic [DW-1:0] got;
    store_word(12'h123, 16'hBEEF);
    fetch_word(12'h123, got);
    check("R3/R4 readback 0x123", 32'(got), 32'hBEEF);
  endtask

  task automatic t_row_col();
    logic [DW-1:0] got;
    // Pairs sharing only a row or only a column must not alias (R6)
    store_word(12'h041, 16'h0041);
    store_word(12'h040, 16'h0040);
    store_word(12'h001, 16'h0001);
    store_word(12'hFC1, 16'h0FC1);
    store_word(12'h07F, 16'h007F);
    fetch_word(12'h041, got); check("R6 cell 0x041", 32'(got), 32'h0041);
    fetch_word(12'h040, got); check("R6 same row 0x040", 32'(got), 32'h0040);
    fetch_word(12'h001, got); check("R6 same col 0x001", 32'(got), 32'h0001);
    fetch_word(12'hFC1, got); check("R6 same col 0xFC1", 32'(got), 32'h0FC1);
    fetch_word(12'h07F, got); check("R6 same row 0x07F", 32'(got), 32'h007F);
  endtask

  task automatic t_corners();
    logic [DW-1:0] got;
    // run_op checks the latency at each address (R9)
    store_word(12'h000, 16'hA001);
    store_word(12'hFFF, 16'h5FFE);
    fetch_word(12'hFFF, got); check("R9 top cell", 32'(got), 32'h5FFE);
    fetch_word(12'h000, got); check("R9 bottom cell", 32'(got), 32'hA001);
  endtask

  task automatic t_busy_ignore();
    logic [DW-1:0] got;
    int pulses;
    load_regs(12'h2A7, 16'hC0DE, 1'b1);
    op = 1'b1; req = 1'b1;
    tick();
    // now in access: loads and a held request must be ignored (R7, R8)
    mar_ld = 1'b1; mar_in = 12'h555;
    mdr_ld = 1'b1; mdr_in = 16'hDEAD;
    pulses = 0;
    tick();
    if (done) pulses++;
    req = 1'b0;
    tick();
    if (done) pulses++;
    mar_ld = 1'b0; mdr_ld = 1'b0;
    check("R7 mar_q held", 32'(mar_q), 32'h2A7);
    check("R7 mdr_q held", 32'(mdr_q), 32'hC0DE);
    for (int i = 0; i < 4; i++) begin
      tick();
      if (done) pulses++;
    end
    check("R8 one done pulse", 32'(pulses), 32'd1);
    fetch_word(12'h2A7, got);
    check("R7 stored value kept", 32'(got), 32'hC0DE);
    fetch_word(12'h555, got);
    check("R8 no write at ignored address", 32'(got), 32'h007F & 32'h0);
  endtask

  initial begin
    #100000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    // preload 0x555 so the ignored-address check has a known value
    store_word(12'h555, 16'h0000);
    t_load();
    t_store_fetch();
    t_row_col();
    t_corners();
    t_busy_ignore();
    fetch_word(12'h123, got);
    check("R4 earlier cell intact", 32'(got), 32'hBEEF);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule